// File: doc/BRIEF.md
# AES-128 Round Key Precompute Engine

This block turns a 128-bit AES cipher key into the eleven 128-bit round keys and keeps them in an internal store of 44 words of 32 bits. A cipher datapath then fetches any word by round number and column through a registered read port. The key arrives as four 32-bit writes. A start strobe then runs the forward expansion, which produces one word per clock.

For decryption, a second strobe rewrites the store in place so that it holds the keys for the equivalent inverse cipher. In that form the InvMixColumns step may come before the key addition. The key for inverse round i is the forward key of round 10-i. For the nine middle rounds, InvMixColumns is also applied to that key, column by column. A busy flag covers each pass, and a one-cycle done pulse marks its end. A full rekey for decryption costs 44 + 48 = 92 busy cycles.

Byte order throughout: a 32-bit word holds bytes a0..a3, with a0 in bits 31:24. The first key word written is the most significant word of the cipher key.

Top module: `rk_expander`

## Requirements
- R1: Each `key_wr` pulse in the idle state stores `key_word` into the next of four key slots, in order from slot 0 to slot 3, wrapping after slot 3. An accepted `exp_start` resets the slot pointer to 0. A key write in the same cycle as an accepted start is dropped. Forward round key 0 equals the four loaded words in load order.
- R2: An `exp_start` seen while idle makes `busy` high for exactly 44 cycles. `busy` then falls, and `done` is high for exactly that one cycle.
- R3: Forward word i (4 ≤ i < 44) equals word i-4 XOR word i-1, except as stated in R4.
- R4: When i is a multiple of 4, forward word i equals word i-4 XOR SubWord(RotWord(word i-1)) XOR {rcon,24'h0}. RotWord maps [a0,a1,a2,a3] to [a1,a2,a3,a0]. SubWord applies the AES S-box to each byte. rcon runs 01,02,04,08,10,20,40,80,1B,36 for rounds 1 to 10.
- R5: An accepted `inv_start` makes `busy` high for exactly 48 cycles, followed by a one-cycle `done`. Afterwards, inverse round key 0 equals forward round key 10, and inverse round key 10 equals forward round key 0.
- R6: After the inverse pass, each column of inverse round key i (1 ≤ i ≤ 9) is InvMixColumns of the same column of forward round key 10-i. Each output byte r is the XOR over j of b_j·c[(j-r) mod 4], with c = {0E,0B,0D,09} and the product taken in GF(2^8) modulo x^8+x^4+x^3+x+1.
- R7: `inv_start` is ignored unless the store holds forward keys from a completed expansion that has not been inverted. This covers the state after reset and a second request after an inverse pass. An ignored request leaves `busy` low and the store unchanged.
- R8: `exp_start`, `inv_start` and `key_wr` are ignored while `busy` is high. The running pass keeps its length and its results, and the key slots and their pointer are unchanged.
- R9: `rd_data` shows the word at index 4·`rd_round`+`rd_col` one cycle after the address is presented. It is zero when `rd_round` > 10, and zero in every cycle after one in which `busy` was high.
- R10: After reset, `busy`, `done` and `rd_data` are low and every stored word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_wr | input | 1 | Write strobe for one cipher key word |
| key_word | input | 32 | Cipher key word, most significant word first |
| exp_start | input | 1 | Start the forward expansion |
| inv_start | input | 1 | Start the inverse-key rewrite |
| busy | output | 1 | A pass is running |
| done | output | 1 | One-cycle pulse after a pass ends |
| rd_round | input | 4 | Round index for the read port |
| rd_col | input | 2 | Column index for the read port |
| rd_data | output | 32 | Registered key word |

## Verification
The checker assumes that reset is asserted before the first pass, and that `busy` goes high only as the start of a pass. On those terms, every `done` closes a run of exactly 44 or 48 busy cycles, and expansion writes fall on consecutive addresses. The bench drives every input on the falling clock edge and holds reset for several cycles. It sends its start, key and inverse strobes both while idle and in the middle of a pass. In the second case the checks confirm that such strobes are ignored, and the assertions still see only well-formed passes.

// File: rtl/rk_pkg.sv
package rk_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_EXP, ST_INV} rk_state_e;

  // multiply by x modulo the AES field polynomial
  function automatic logic [7:0] gf_xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] t;
    acc = 8'h00;
    t   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc ^= t;
      t = gf_xtime(t);
    end
    return acc;
  endfunction

  // a^254 by repeated squaring; zero maps to zero
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] sq;
    logic [7:0] r;
    sq = a;
    r  = 8'h01;
    for (int i = 1; i < 8; i++) begin
      sq = gf_mul(sq, sq);
      r  = gf_mul(r, sq);
    end
    return r;
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] a);
    logic [7:0] b;
    b = gf_inv(a);
    return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]}
             ^ {b[3:0], b[7:4]} ^ 8'h63;
  endfunction

  function automatic logic [31:0] rot_word(input logic [31:0] w);
    return {w[23:0], w[31:24]};
  endfunction

  function automatic logic [31:0] sub_word(input logic [31:0] w);
    return {sbox(w[31:24]), sbox(w[23:16]), sbox(w[15:8]), sbox(w[7:0])};
  endfunction

  function automatic logic [31:0] inv_mix_col(input logic [31:0] w);
    logic [7:0] b0, b1, b2, b3;
    b0 = w[31:24]; b1 = w[23:16]; b2 = w[15:8]; b3 = w[7:0];
    return {gf_mul(b0,8'h0e) ^ gf_mul(b1,8'h0b) ^ gf_mul(b2,8'h0d) ^ gf_mul(b3,8'h09),
            gf_mul(b0,8'h09) ^ gf_mul(b1,8'h0e) ^ gf_mul(b2,8'h0b) ^ gf_mul(b3,8'h0d),
            gf_mul(b0,8'h0d) ^ gf_mul(b1,8'h09) ^ gf_mul(b2,8'h0e) ^ gf_mul(b3,8'h0b),
            gf_mul(b0,8'h0b) ^ gf_mul(b1,8'h0d) ^ gf_mul(b2,8'h09) ^ gf_mul(b3,8'h0e)};
  endfunction

endpackage

// File: rtl/rk_store.sv
module rk_store #(
  parameter int DEPTH = 44,
  parameter int AW    = 6,
  parameter int NR    = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [AW-1:0]          waddr,
  input  logic [31:0]            wdata,
  input  logic [NR-1:0][AW-1:0]  raddr,
  output logic [NR-1:0][31:0]    rdata
);
  logic [31:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we && (int'(waddr) < DEPTH)) begin
      mem_q[waddr] <= wdata;
    end
  end

  for (genvar p = 0; p < NR; p++) begin : g_rd
    assign rdata[p] = (int'(raddr[p]) < DEPTH) ? mem_q[raddr[p]] : '0;
  end
endmodule

// File: rtl/rk_word_gen.sv
module rk_word_gen import rk_pkg::*; #(
  parameter int AW = 6
) (
  input  logic [AW-1:0] idx,
  input  logic [31:0]   prev,
  input  logic [31:0]   back,
  input  logic [31:0]   key_word,
  input  logic [7:0]    rcon,
  output logic [31:0]   word
);
  always_comb begin
    if (int'(idx) < 4)
      word = key_word;
    else if (idx[1:0] == 2'd0)
      word = back ^ sub_word(rot_word(prev)) ^ {rcon, 24'h0};
    else
      word = back ^ prev;
  end
endmodule

// File: rtl/rk_inv_gen.sv
module rk_inv_gen import rk_pkg::*; (
  input  logic [31:0] src,
  input  logic        keep,
  output logic [31:0] word
);
  assign word = keep ? src : inv_mix_col(src);
endmodule

// File: rtl/rk_expander.sv
module rk_expander import rk_pkg::*; #(
  parameter  int ROUNDS = 10,
  localparam int RW     = $clog2(ROUNDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          key_wr,
  input  logic [31:0]   key_word,
  input  logic          exp_start,
  input  logic          inv_start,
  output logic          busy,
  output logic          done,
  input  logic [RW-1:0] rd_round,
  input  logic [1:0]    rd_col,
  output logic [31:0]   rd_data
);
  localparam int NK      = 4;
  localparam int TOTAL   = NK * (ROUNDS + 1);
  localparam int RAW     = RW + 2;
  localparam int HALF    = ROUNDS / 2;                 // ROUNDS assumed even
  localparam int INV_CYC = 2 * NK * (HALF + 1);
  localparam int CW      = $clog2(INV_CYC > TOTAL ? INV_CYC : TOTAL);

  rk_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic [7:0]    rcon_q;
  logic [31:0]   hold_q;
  logic          fwd_ok_q;
  logic [31:0]   key_q [NK];
  logic [1:0]    ld_ptr_q;
  logic          done_q;
  logic [31:0]   rd_q;

  // named events for the checker
  logic st_idle, st_exp, st_inv;
  logic accept_exp, accept_inv, exp_last, inv_last, rcon_step, phase_b;
  logic wr_en;
  logic [RAW-1:0] wr_addr;
  logic [31:0]    wr_data;

  logic [RAW-1:0] exp_idx, lo_addr, hi_addr, rc_addr;
  logic [CW-2:0]  slot;
  logic [RW-1:0]  lo_round, hi_round;
  logic [31:0]    exp_word, inv_word, inv_src;
  logic [2:0][RAW-1:0] raddr;
  logic [2:0][31:0]    rdata;

  assign st_idle    = (state_q == ST_IDLE);
  assign st_exp     = (state_q == ST_EXP);
  assign st_inv     = (state_q == ST_INV);
  assign accept_exp = st_idle && exp_start;
  assign accept_inv = st_idle && inv_start && !exp_start && fwd_ok_q;
  assign exp_last   = st_exp && (int'(cnt_q) == TOTAL - 1);
  assign inv_last   = st_inv && (int'(cnt_q) == INV_CYC - 1);

  assign exp_idx   = RAW'(cnt_q);
  assign rcon_step = st_exp && (int'(exp_idx) >= NK) && (exp_idx[1:0] == 2'd0);

  // inverse pass: slot s pairs round s/4 with round ROUNDS-s/4, same column
  assign phase_b  = cnt_q[0];
  assign slot     = cnt_q[CW-1:1];
  assign lo_round = RW'(slot >> 2);
  assign hi_round = RW'(ROUNDS) - lo_round;
  assign lo_addr  = {lo_round, slot[1:0]};
  assign hi_addr  = {hi_round, slot[1:0]};
  assign rc_addr  = {rd_round, rd_col};

  assign raddr[0] = st_inv ? hi_addr : exp_idx - RAW'(1);
  assign raddr[1] = st_inv ? lo_addr : exp_idx - RAW'(4);
  assign raddr[2] = rc_addr;

  assign inv_src = phase_b ? hold_q : rdata[0];

  rk_word_gen #(.AW(RAW)) u_gen (
    .idx(exp_idx), .prev(rdata[0]), .back(rdata[1]),
    .key_word(key_q[exp_idx[1:0]]), .rcon(rcon_q), .word(exp_word)
  );

  rk_inv_gen u_inv (
    .src(inv_src), .keep(lo_round == '0), .word(inv_word)
  );

  assign wr_en   = st_exp || st_inv;
  assign wr_addr = st_inv ? (phase_b ? hi_addr : lo_addr) : exp_idx;
  assign wr_data = st_inv ? inv_word : exp_word;

  rk_store #(.DEPTH(TOTAL), .AW(RAW), .NR(3)) u_store (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr(raddr), .rdata(rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      rcon_q   <= 8'h01;
      hold_q   <= '0;
      fwd_ok_q <= 1'b0;
      ld_ptr_q <= '0;
      done_q   <= 1'b0;
      rd_q     <= '0;
      for (int k = 0; k < NK; k++) key_q[k] <= '0;
    end else begin
      done_q <= exp_last || inv_last;
      rd_q   <= st_idle ? rdata[2] : '0;
      case (state_q)
        ST_IDLE: begin
          if (accept_exp) begin
            state_q  <= ST_EXP;
            cnt_q    <= '0;
            rcon_q   <= 8'h01;
            ld_ptr_q <= '0;
            fwd_ok_q <= 1'b0;
          end else if (accept_inv) begin
            state_q <= ST_INV;
            cnt_q   <= '0;
          end else if (key_wr) begin
            key_q[ld_ptr_q] <= key_word;
            ld_ptr_q        <= ld_ptr_q + 2'd1;
          end
        end
        ST_EXP: begin
          if (rcon_step) rcon_q <= gf_xtime(rcon_q);
          if (exp_last) begin
            state_q  <= ST_IDLE;
            fwd_ok_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_INV: begin
          if (!phase_b) hold_q <= rdata[1];
          if (inv_last) begin
            state_q  <= ST_IDLE;
            fwd_ok_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy    = !st_idle;
  assign done    = done_q;
  assign rd_data = rd_q;
endmodule

// File: rtl/rk_expander_chk.sv
module rk_expander_chk #(
  parameter int TOTAL   = 44,
  parameter int INV_CYC = 48,
  parameter int AW      = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic [31:0]   rd_data,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          st_exp
);
  logic [7:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 8'd1;
    else           run_len <= '0;
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R2
  AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && (run_len == 8'(TOTAL) || run_len == 8'(INV_CYC)))); // R5
  AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n) busy |=> (rd_data == 32'h0)); // R9
  AST_WRITE_IN_PASS: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> busy); // R7
  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> (int'(wr_addr) < TOTAL)); // R3
  AST_EXP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (st_exp && wr_en && $past(st_exp && wr_en)) |-> (wr_addr == $past(wr_addr) + AW'(1))); // R3
endmodule

bind rk_expander rk_expander_chk #(.TOTAL(TOTAL), .INV_CYC(INV_CYC), .AW(RAW)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .rd_data(rd_data),
  .wr_en(wr_en), .wr_addr(wr_addr), .st_exp(st_exp)
);

// File: tb/rk_expander_tb.sv
`timescale 1ns/1ps
module rk_expander_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        key_wr = 1'b0;
  logic [31:0] key_word = '0;
  logic        exp_start = 1'b0;
  logic        inv_start = 1'b0;
  logic        busy, done;
  logic [3:0]  rd_round = '0;
  logic [1:0]  rd_col = '0;
  logic [31:0] rd_data;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] mw [0:43];
  logic [31:0] mi [0:43];

  always #2 clk = ~clk;

  rk_expander dut_i (
    .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_word(key_word),
    .exp_start(exp_start), .inv_start(inv_start), .busy(busy), .done(done),
    .rd_round(rd_round), .rd_col(rd_col), .rd_data(rd_data)
  );

  // ---------------- reference arithmetic ----------------
  function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p;
    p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p ^= (16'(a) << i);
    for (int i = 15; i >= 8; i--) if (p[i]) p ^= (16'h011b << (i - 8));
    return p[7:0];
  endfunction

  function automatic logic [7:0] m_sbox(input logic [7:0] a);
    logic [7:0] b, s, c;
    b = 8'h00;
    if (a != 8'h00)
      for (int x = 1; x < 256; x++) if (m_mul(a, 8'(x)) == 8'h01) b = 8'(x);
    c = 8'h63;
    for (int i = 0; i < 8; i++)
      s[i] = b[i] ^ b[(i+4)%8] ^ b[(i+5)%8] ^ b[(i+6)%8] ^ b[(i+7)%8] ^ c[i];
    return s;
  endfunction

  function automatic logic [31:0] m_imc(input logic [31:0] w);
    logic [7:0] b [4];
    logic [7:0] cf [4];
    logic [7:0] o;
    logic [31:0] r;
    cf[0] = 8'h0e; cf[1] = 8'h0b; cf[2] = 8'h0d; cf[3] = 8'h09;
    for (int j = 0; j < 4; j++) b[j] = w[31-8*j -: 8];
    r = '0;
    for (int k = 0; k < 4; k++) begin
      o = 8'h00;
      for (int j = 0; j < 4; j++) o ^= m_mul(b[j], cf[(j - k + 4) % 4]);
      r[31-8*k -: 8] = o;
    end
    return r;
  endfunction

  task automatic model(input logic [127:0] k);
    logic [31:0] t;
    logic [7:0]  rc;
    rc = 8'h01;
    for (int i = 0; i < 4; i++) mw[i] = k[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = mw[i-1];
      if (i % 4 == 0) begin
        t = {t[23:0], t[31:24]};
        t = {m_sbox(t[31:24]), m_sbox(t[23:16]), m_sbox(t[15:8]), m_sbox(t[7:0])};
        t ^= {rc, 24'h0};
        rc = m_mul(rc, 8'h02);
      end
      mw[i] = mw[i-4] ^ t;
    end
    for (int r = 0; r <= 10; r++)
      for (int c = 0; c < 4; c++)
        mi[4*r+c] = (r == 0 || r == 10) ? mw[4*(10-r)+c] : m_imc(mw[4*(10-r)+c]);
  endtask

  // ---------------- bench helpers ----------------
  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_word(input int r, input int c, output logic [31:0] v);
    @(negedge clk);
    rd_round = 4'(r);
    rd_col   = 2'(c);
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic load_key(input logic [127:0] k);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      key_wr = 1'b1;
      key_word = k[127-32*i -: 32];
    end
    @(negedge clk);
    key_wr = 1'b0;
  endtask

  task automatic run_pass(input bit inv, input int exp_len, input bit inject, input string req);
    int n;
    @(negedge clk);
    if (inv) inv_start = 1'b1; else exp_start = 1'b1;
    @(negedge clk);
    inv_start = 1'b0;
    exp_start = 1'b0;
    check32(req, 32'(busy), 32'd1);
    n = 0;
    while (busy && n < 200) begin
      if (inject && n == 5) begin
        key_wr = 1'b1; key_word = 32'hdeadbeef; exp_start = 1'b1; inv_start = 1'b1;
      end else if (inject && n == 6) begin
        key_wr = 1'b1; key_word = 32'h12345678; exp_start = 1'b0; inv_start = 1'b0;
      end else begin
        key_wr = 1'b0; exp_start = 1'b0; inv_start = 1'b0;
      end
      if (inject && n == 10) check32("R9 rd_data zero while busy", rd_data, 32'h0);
      @(negedge clk);
      n++;
    end
    key_wr = 1'b0;
    check32({req, " busy length"}, 32'(n), 32'(exp_len));
    check32({req, " done pulse"}, 32'(done), 32'd1);
    @(negedge clk);
    check32("R2 done drops", 32'(done), 32'd0);
  endtask

  task automatic cmp_forward();
    logic [31:0] v;
    for (int i = 0; i < 44; i++) begin
      read_word(i / 4, i % 4, v);
      if (i < 4)           check32("R1 round key 0", v, mw[i]);
      else if (i % 4 == 0) check32("R4 rcon word", v, mw[i]);
      else                 check32("R3 xor word", v, mw[i]);
    end
  endtask

  task automatic cmp_inverse();
    logic [31:0] v;
    for (int i = 0; i < 44; i++) begin
      read_word(i / 4, i % 4, v);
      if (i < 4 || i >= 40) check32("R5 end keys swapped", v, mi[i]);
      else                  check32("R6 middle key InvMixColumns", v, mi[i]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [127:0] keys [4];
    keys[0] = 128'h2b7e151628aed2a6abf7158809cf4f3c;
    keys[1] = 128'h0;
    keys[2] = {4{32'hffffffff}};
    keys[3] = 128'h000102030405060708090a0b0c0d0e0f;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check32("R10 busy after reset", 32'(busy), 32'd0);
    check32("R10 done after reset", 32'(done), 32'd0);
    read_word(3, 2, v);
    check32("R10 store cleared", v, 32'h0);

    // R7: inverse request with no forward keys
    @(negedge clk); inv_start = 1'b1;
    @(negedge clk); inv_start = 1'b0;
    check32("R7 inv ignored after reset", 32'(busy), 32'd0);

    for (int k = 0; k < 4; k++) begin
      model(keys[k]);
      load_key(keys[k]);
      run_pass(1'b0, 44, 1'b0, "R2 expansion");
      cmp_forward();
      if (k == 0) begin
        read_word(1, 0, v);  check32("R4 known vector w4", v, 32'ha0fafe17);
        read_word(10, 0, v); check32("R4 known vector w40", v, 32'hd014f9a8);
        read_word(10, 3, v); check32("R3 known vector w43", v, 32'hb6630ca6);
      end
      for (int r = 11; r < 16; r++) begin
        read_word(r, r % 4, v);
        check32("R9 out of range round", v, 32'h0);
      end
      run_pass(1'b1, 48, 1'b0, "R5 inverse");
      cmp_inverse();
      // R7: second inverse request is refused
      @(negedge clk); inv_start = 1'b1;
      @(negedge clk); inv_start = 1'b0;
      check32("R7 second inv ignored", 32'(busy), 32'd0);
      read_word(2, 1, v);
      check32("R7 store unchanged", v, mi[9]);
    end

    // R8: strobes during a pass are ignored
    model(keys[0]);
    load_key(keys[0]);
    read_word(10, 0, v);
    run_pass(1'b0, 44, 1'b1, "R8 expansion with strobes");
    cmp_forward();
    run_pass(1'b0, 44, 1'b0, "R8 rerun from held key");
    cmp_forward();

    // R1: partial load then start resets the slot pointer
    @(negedge clk); key_wr = 1'b1; key_word = 32'hcafef00d;
    @(negedge clk); key_word = 32'h0badf00d;
    @(negedge clk); key_wr = 1'b0;
    run_pass(1'b0, 44, 1'b0, "R2 expansion after partial load");
    model(keys[3]);
    load_key(keys[3]);
    run_pass(1'b0, 44, 1'b0, "R1 expansion after pointer reset");
    cmp_forward();

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule